// File: doc/BRIEF.md
# Priority-Grouped Interrupt Router

This block collects interrupt requests from a set of peripheral sources and hands each one to a core interface. A rising edge on a source request line is stored as a pending flag. A flag is stored only while that source is enabled. Each source carries a target field that points at exactly one core interface, and a priority level.

Every core interface has its own arbiter. The arbiter looks at the pending, enabled sources aimed at that core and chooses one in two steps. First it takes the numerically smallest priority level among them. Then, within that level, it takes the smallest source ID. The chosen ID is shown on the core's outputs with a valid flag. Both stay frozen until the core acknowledges. The acknowledge clears that source's pending flag, and arbitration resumes one cycle later.

A global enable and a per-core enable gate the start of every new forwarding. Pending flags are still collected while either enable is low. When every source is left at level 0, the order is decided purely by source ID.

Top module: `irq_router`

## Requirements
- R1: No core interface raises its valid flag unless the global enable was high in the cycle before the rise. Edges that arrive while the global enable is low stay pending and are forwarded once it is set.
- R2: A core interface whose enable is low never raises its valid flag. Other cores keep forwarding their own sources meanwhile.
- R3: A rising request edge from a source whose enable bit is low is not latched. Enabling the source afterwards produces no forwarding from that earlier edge.
- R4: A source is forwarded only on the core interface selected by its target field. Target value k means core k.
- R5: When all sources have priority level 0, pending sources aimed at one core are forwarded in ascending source ID order.
- R6: Among pending sources aimed at one core, a source with a numerically lower priority level is forwarded before any source with a higher level, whatever their IDs.
- R7: Among pending sources with the same level aimed at one core, the lower source ID is forwarded first.
- R8: A pending flag is set only by a 0-to-1 transition of the request line. A request held high after its acknowledge is not forwarded again.
- R9: While a core's valid flag is high and its acknowledge is low, the valid flag and the forwarded ID stay unchanged. This holds even if a higher-priority source becomes pending.
- R10: In the cycle after an acknowledge, the valid flag is low. If more sources are pending for that core, the valid flag is high again in the cycle after that.
- R11: After reset, every core's valid flag is low and no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global routing enable |
| core_en | input | N_CORE | Per-core interface enable |
| src_en | input | N_SRC | Per-source enable |
| src_tgt | input | N_SRC*TGT_W | Target core index per source; source s uses bits [s*TGT_W +: TGT_W] |
| src_lvl | input | N_SRC*LVL_W | Priority level per source (0 is highest); source s uses bits [s*LVL_W +: LVL_W] |
| src_req | input | N_SRC | Request lines; a rising edge makes a source pending |
| core_ack | input | N_CORE | Per-core acknowledge of the presented ID |
| core_vld | output | N_CORE | Per-core valid flag |
| core_id | output | N_CORE*ID_W | Per-core forwarded source ID; core c uses bits [c*ID_W +: ID_W] |

## Verification
The hardest situation to reach is a core holding one ID while a better candidate arrives, so that the freeze must override a changed arbitration result. The bench produces it by raising a low-priority source first. It waits for that source to be presented, then pulses source 0 and keeps the acknowledge low for several cycles. Before each drain, the priority order is set up by sweeping level and target assignments that are computed arithmetically from the source ID. The bench then predicts every forwarded ID from its own model of the pending set and checks the sequence.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   // Width needed to index n items, never below one bit.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] req,
   input  logic [N_SRC-1:0] en,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] pend
);
   logic [N_SRC-1:0] req_q;
   logic [N_SRC-1:0] rise;

   assign rise = req & ~req_q & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         pend  <= '0;
      end else begin
         req_q <= req;
         pend  <= (pend & ~clr) | rise;
      end
   end
endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb
   import irq_router_pkg::*;
#(
   parameter int N_SRC = 16,
   parameter int N_LVL = 4,
   localparam int ID_W  = idx_w(N_SRC),
   localparam int LVL_W = idx_w(N_LVL)
) (
   input  logic [N_SRC-1:0]       cand,
   input  logic [N_SRC*LVL_W-1:0] lvl,
   output logic                   any,
   output logic [ID_W-1:0]        win
);
   logic [N_SRC-1:0] filt;

   generate
      if (N_LVL == 1) begin : g_flat
         assign filt = cand;
      end else begin : g_grouped
         logic [N_SRC-1:0] lvl_mask [N_LVL];
         logic [LVL_W-1:0] best;
         always_comb begin
            for (int l = 0; l < N_LVL; l++) begin
               for (int s = 0; s < N_SRC; s++) begin
                  lvl_mask[l][s] = cand[s] && (lvl[s*LVL_W +: LVL_W] == LVL_W'(l));
               end
            end
            best = '0;
            for (int l = N_LVL - 1; l >= 0; l--) begin
               if (|lvl_mask[l]) best = LVL_W'(l);
            end
            filt = '0;
            for (int s = 0; s < N_SRC; s++) begin
               filt[s] = cand[s] && (lvl[s*LVL_W +: LVL_W] == best);
            end
         end
      end
   endgenerate

   always_comb begin
      any = |filt;
      win = '0;
      for (int s = N_SRC - 1; s >= 0; s--) begin
         if (filt[s]) win = ID_W'(s);
      end
   end
endmodule

// File: rtl/irq_core_port.sv
module irq_core_port
   import irq_router_pkg::*;
#(
   parameter int N_SRC = 16,
   localparam int ID_W = idx_w(N_SRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            allow,
   input  logic            arb_any,
   input  logic [ID_W-1:0] arb_win,
   input  logic            ack,
   output logic            vld,
   output logic [ID_W-1:0] id,
   output logic            take
);
   assign take = vld & ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         id  <= '0;
      end else if (vld) begin
         if (ack) vld <= 1'b0;
      end else if (allow && arb_any) begin
         vld <= 1'b1;
         id  <= arb_win;
      end
   end
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 16,
   parameter int N_CORE = 2,
   parameter int N_LVL  = 4,
   localparam int ID_W  = idx_w(N_SRC),
   localparam int TGT_W = idx_w(N_CORE),
   localparam int LVL_W = idx_w(N_LVL)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    glob_en,
   input  logic [N_CORE-1:0]       core_en,
   input  logic [N_SRC-1:0]        src_en,
   input  logic [N_SRC*TGT_W-1:0]  src_tgt,
   input  logic [N_SRC*LVL_W-1:0]  src_lvl,
   input  logic [N_SRC-1:0]        src_req,
   input  logic [N_CORE-1:0]       core_ack,
   output logic [N_CORE-1:0]       core_vld,
   output logic [N_CORE*ID_W-1:0]  core_id
);
   initial begin
      if (N_SRC < 2)  $error("irq_router: N_SRC must be at least 2");
      if (N_CORE < 1) $error("irq_router: N_CORE must be at least 1");
      if (N_LVL < 1)  $error("irq_router: N_LVL must be at least 1");
   end

   logic [N_SRC-1:0]  pend;
   logic [N_SRC-1:0]  clr;
   logic [N_SRC-1:0]  held;
   logic [N_CORE-1:0] take;
   logic [ID_W-1:0]   id_w [N_CORE];

   irq_pend #(.N_SRC(N_SRC)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (src_req),
      .en   (src_en),
      .clr  (clr),
      .pend (pend)
   );

   // Sources on display anywhere are withheld from every arbiter, and
   // an acknowledge retires the displayed source.
   always_comb begin
      held = '0;
      clr  = '0;
      for (int c = 0; c < N_CORE; c++) begin
         for (int s = 0; s < N_SRC; s++) begin
            if (core_vld[c] && (id_w[c] == ID_W'(s))) held[s] = 1'b1;
            if (take[c] && (id_w[c] == ID_W'(s)))     clr[s]  = 1'b1;
         end
      end
   end

   generate
      for (genvar c = 0; c < N_CORE; c++) begin : g_core
         logic [N_SRC-1:0] cand;
         logic             arb_any;
         logic [ID_W-1:0]  arb_win;

         always_comb begin
            for (int s = 0; s < N_SRC; s++) begin
               cand[s] = pend[s] && src_en[s] && !held[s] &&
                         (src_tgt[s*TGT_W +: TGT_W] == TGT_W'(c));
            end
         end

         irq_lvl_arb #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_arb (
            .cand(cand),
            .lvl (src_lvl),
            .any (arb_any),
            .win (arb_win)
         );

         irq_core_port #(.N_SRC(N_SRC)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .allow  (glob_en && core_en[c]),
            .arb_any(arb_any),
            .arb_win(arb_win),
            .ack    (core_ack[c]),
            .vld    (core_vld[c]),
            .id     (id_w[c]),
            .take   (take[c])
         );

         assign core_id[c*ID_W +: ID_W] = id_w[c];
      end
   endgenerate
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 16,
   parameter int N_CORE = 2,
   parameter int N_LVL  = 4,
   localparam int ID_W  = idx_w(N_SRC),
   localparam int TGT_W = idx_w(N_CORE)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   glob_en,
   input logic [N_CORE-1:0]      core_en,
   input logic [N_SRC-1:0]       src_en,
   input logic [N_SRC*TGT_W-1:0] src_tgt,
   input logic [N_CORE-1:0]      core_ack,
   input logic [N_CORE-1:0]      core_vld,
   input logic [N_CORE*ID_W-1:0] core_id
);
   function automatic logic [TGT_W-1:0] tgt_of(input logic [N_SRC*TGT_W-1:0] v,
                                                input logic [ID_W-1:0] i);
      return v[i*TGT_W +: TGT_W];
   endfunction

   function automatic logic bit_of(input logic [N_SRC-1:0] v, input logic [ID_W-1:0] i);
      return v[i];
   endfunction

   generate
      for (genvar c = 0; c < N_CORE; c++) begin : g_chk
         logic [ID_W-1:0] idc;
         assign idc = core_id[c*ID_W +: ID_W];

         p_glob_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_vld[c]) |-> $past(glob_en));
         p_core_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_vld[c]) |-> $past(core_en[c]));
         p_src_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_vld[c]) |-> bit_of($past(src_en), idc));
         p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_vld[c]) |-> (tgt_of($past(src_tgt), idc) == TGT_W'(c)));
         p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (core_vld[c] && !core_ack[c]) |=> (core_vld[c] && $stable(idc)));
         p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (core_vld[c] && core_ack[c]) |=> !core_vld[c]);
      end
   endgenerate
endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LVL(N_LVL)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .glob_en (glob_en),
   .core_en (core_en),
   .src_en  (src_en),
   .src_tgt (src_tgt),
   .core_ack(core_ack),
   .core_vld(core_vld),
   .core_id (core_id)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
   localparam int NS = 16;
   localparam int NC = 2;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          glob_en = 1'b1;
   logic [NC-1:0] core_en = '1;
   logic [NS-1:0] src_en = '1;
   logic [NS-1:0] src_tgt;
   logic [NS*2-1:0] src_lvl;
   logic [NS-1:0] src_req = '0;
   logic [NC-1:0] core_ack = '0;
   logic [NC-1:0] core_vld;
   logic [NC*IW-1:0] core_id;

   int lvl_b [NS];
   int tgt_b [NS];
   logic [NS-1:0] exp_pend = '0;
   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   always_comb begin
      for (int s = 0; s < NS; s++) begin
         src_tgt[s]         = tgt_b[s][0];
         src_lvl[s*2 +: 2]  = 2'(lvl_b[s]);
      end
   end

   irq_router #(.N_SRC(NS), .N_CORE(NC), .N_LVL(4)) u_irq_router (
      .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .core_en(core_en),
      .src_en(src_en), .src_tgt(src_tgt), .src_lvl(src_lvl), .src_req(src_req),
      .core_ack(core_ack), .core_vld(core_vld), .core_id(core_id)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int remaining(input int c);
      int n = 0;
      for (int s = 0; s < NS; s++) if (exp_pend[s] && tgt_b[s] == c) n++;
      return n;
   endfunction

   function automatic int pick(input int c);
      int best = -1;
      for (int s = 0; s < NS; s++)
         if (exp_pend[s] && tgt_b[s] == c && (best < 0 || lvl_b[s] < lvl_b[best])) best = s;
      return best;
   endfunction

   function automatic int id_of(input int c);
      return int'(core_id[c*IW +: IW]);
   endfunction

   task automatic pulse(input logic [NS-1:0] m);
      @(negedge clk);
      src_req = m;
      exp_pend = exp_pend | (m & src_en);
      @(negedge clk);
      src_req = '0;
   endtask

   task automatic idle_check(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(core_vld == '0, tag, int'(core_vld), 0);
      end
   endtask

   task automatic drain(input int c, input string tag);
      int guard;
      int e;
      while (remaining(c) != 0) begin
         guard = 0;
         while (!core_vld[c] && guard < 20) begin
            @(negedge clk);
            guard++;
         end
         e = pick(c);
         check(core_vld[c], tag, int'(core_vld[c]), 1);
         check(id_of(c) == e, tag, id_of(c), e);
         core_ack[c] = 1'b1;
         @(negedge clk);
         core_ack[c] = 1'b0;
         exp_pend[e] = 1'b0;
         check(!core_vld[c], "R10 drop", int'(core_vld[c]), 0);
         if (remaining(c) != 0) begin
            @(negedge clk);
            check(core_vld[c], "R10 rearb", int'(core_vld[c]), 1);
         end
      end
   endtask

   task automatic set_cfg(input int lv_mode, input int tg_mode);
      for (int s = 0; s < NS; s++) begin
         lvl_b[s] = (lv_mode < 0) ? 0 : ((s * 5 + lv_mode) % 4);
         tgt_b[s] = (tg_mode < 0) ? 0 : ((s >> tg_mode) & 1);
      end
   endtask

   initial begin
      set_cfg(-1, -1);
      repeat (3) @(negedge clk);
      check(core_vld == '0, "R11 vld", int'(core_vld), 0);
      rst_n = 1'b1;
      idle_check(3, "R11 idle");

      // R5: flat level, ascending ID order over a sweep of masks
      for (int i = 1; i <= 8; i++) begin
         pulse(16'((i * 16'h2F35) ^ (i << 3)));
         drain(0, "R5");
      end

      // R6 R7: levels derived from ID, level first then ID
      for (int i = 0; i < 4; i++) begin
         set_cfg(i, -1);
         pulse(16'hFFFF);
         drain(0, "R6");
         pulse(16'((i + 3) * 16'h1B4D));
         drain(0, "R7");
      end

      // R4: target chosen by one ID bit, both cores
      for (int i = 0; i < 4; i++) begin
         set_cfg(i, i);
         pulse(16'hFFFF);
         drain(1, "R4");
         drain(0, "R4");
      end

      // R1: global gate
      set_cfg(-1, -1);
      glob_en = 1'b0;
      pulse(16'h0030);
      idle_check(6, "R1 gated");
      glob_en = 1'b1;
      drain(0, "R1");

      // R2: per-core gate
      set_cfg(-1, 0);
      core_en = 2'b10;
      pulse(16'h000F);
      drain(1, "R2");
      @(negedge clk);
      check(!core_vld[0], "R2 gated", int'(core_vld[0]), 0);
      core_en = 2'b11;
      drain(0, "R2");

      // R3: disabled source edge not latched
      set_cfg(-1, -1);
      src_en = ~16'h0100;
      pulse(16'h0100);
      idle_check(4, "R3 masked");
      src_en = '1;
      idle_check(4, "R3 later");
      pulse(16'h0100);
      drain(0, "R3");

      // R8: level held high forwards once
      @(negedge clk);
      src_req = 16'h0004;
      exp_pend[2] = 1'b1;
      drain(0, "R8");
      idle_check(6, "R8 held");
      src_req = '0;
      pulse(16'h0004);
      drain(0, "R8");

      // R9: presented ID frozen while a better source arrives
      set_cfg(-1, -1);
      pulse(16'h0080);
      for (int g = 0; g < 20 && !core_vld[0]; g++) @(negedge clk);
      check(id_of(0) == 7, "R9 first", id_of(0), 7);
      pulse(16'h0001);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(core_vld[0] && id_of(0) == 7, "R9 hold", id_of(0), 7);
      end
      core_ack[0] = 1'b1;
      @(negedge clk);
      core_ack[0] = 1'b0;
      exp_pend[7] = 1'b0;
      drain(0, "R9");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule